// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the processor-side engine that decides whether an interrupt is taken at an instruction boundary and then carries out the real-mode entry. At each boundary it looks at the pending sources and picks one. The sources are a divide fault, an overflow trap, a software interrupt with an immediate vector, a qualified non-maskable line and a maskable request with an 8-bit vector. Once a source is picked, the block saves FLAGS, CS and IP on the stack, fetches the handler address from the vector table at physical address zero, and hands the new CS:IP, FLAGS and SP to the datapath in a single load pulse. A return request at a boundary runs the reverse sequence and restores the saved state.

Stack writes and table reads share one synchronous request/response memory port. A request is held until the memory acknowledges it. The non-maskable line must stay high for several clocks before it counts. A write to SS shuts out external sources at the boundary that ends that instruction.

Top module: `irq_entry_seq`

## Requirements
- R1: An NMI becomes pending only after `nmi_i` has been sampled high on NMI_HOLD+1 (default 5) consecutive rising clock edges. A high pulse of 4 edges is ignored. An accepted NMI uses vector 0x02, and flag IF does not affect it.
- R2: A single high period of `nmi_i` gives at most one acceptance. The line must go low before another NMI can become pending.
- R3: A maskable request (`intr_req_i`, vector `intr_vec_i`) is accepted only when FLAGS bit 9 (IF) is 1.
- R4: A divide fault is accepted with vector 0x00 whatever IF is. An overflow trap is accepted with vector 0x04 only when FLAGS bit 11 (OF) is 1. When OF is 0 it starts no sequence.
- R5: A software request is accepted with vector `sw_vec_i` whatever IF is.
- R6: When several sources are present at one boundary, the order of precedence is: divide fault, then overflow trap, then software, then return, then NMI, then maskable. Sources that lose keep waiting.
- R7: A pulse on `ss_write_i` blocks NMI and maskable acceptance at the next boundary, including a boundary in the same cycle. The boundary after that one is open again.
- R8: Entry makes three stack writes, in this order: FLAGS at SS:SP-2, CS at SS:SP-4, IP at SS:SP-6. The physical address is segment*16 + offset, truncated to 20 bits.
- R9: Entry then reads the offset at vector*4 and the segment at vector*4+2. It then pulses `load_o` with the new IP set to the offset, the new CS set to the segment, the new SP set to SP-6, and the new FLAGS set to the saved FLAGS with bits 9 (IF) and 8 (TF) cleared.
- R10: A return reads IP at SS:SP, CS at SS:SP+2 and FLAGS at SS:SP+4. It then pulses `load_o` with those three values and a new SP of SP+6.
- R11: While a sequence is running, `busy_o` is high and nothing is accepted. `busy_o` falls on the cycle after `load_o`.
- R12: After reset `busy_o`, `load_o`, `accept_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction boundary, one cycle |
| ss_write_i | input | 1 | Current instruction writes SS |
| nmi_i | input | 1 | Non-maskable interrupt line |
| intr_req_i | input | 1 | Maskable request, level |
| intr_vec_i | input | 8 | Maskable vector number |
| sw_req_i | input | 1 | Software interrupt at this boundary |
| sw_vec_i | input | 8 | Software vector number |
| div_fault_i | input | 1 | Divide by zero or divide overflow |
| ovf_trap_i | input | 1 | Overflow-trap instruction |
| iret_i | input | 1 | Return instruction at this boundary |
| flags_i | input | 16 | Current FLAGS |
| cs_i | input | 16 | Current CS |
| ip_i | input | 16 | Return IP |
| ss_i | input | 16 | Current SS |
| sp_i | input | 16 | Current SP |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 20 | Physical address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Memory acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| accept_o | output | 1 | An interrupt is accepted this cycle |
| accept_vec_o | output | 8 | Accepted vector number |
| busy_o | output | 1 | Entry or return sequence running |
| load_o | output | 1 | New state is valid, one cycle |
| new_cs_o | output | 16 | CS to load |
| new_ip_o | output | 16 | IP to load |
| new_flags_o | output | 16 | FLAGS to load |
| new_sp_o | output | 16 | SP to load |

## Verification
The properties assume that `flags_i` stays steady during a boundary cycle and that the memory acknowledges only a request that is present. They also assume `iret_i` is never raised together with a software or fault request, because the decode stage issues only one of these per instruction. The stimulus drives every input just after the falling edge and holds it for whole cycles. Its memory model acknowledges one cycle after each request. It raises instruction-class sources only one at a time, except in the precedence scenario, and there it never combines them with a return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 20;
  localparam int WORD_W = 16;
  localparam int IF_BIT = 9;
  localparam int TF_BIT = 8;
  localparam int OF_BIT = 11;
  localparam logic [7:0] VEC_DIV = 8'h00;
  localparam logic [7:0] VEC_NMI = 8'h02;
  localparam logic [7:0] VEC_OVF = 8'h04;

  typedef enum logic [1:0] {SRC_NONE, SRC_INT, SRC_NMI, SRC_EXT} src_t;

  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_F, S_PUSH_CS, S_PUSH_IP, S_RD_OFF, S_RD_SEG,
    S_POP_IP, S_POP_CS, S_POP_F, S_LOAD
  } seq_t;

  function automatic logic [ADDR_W-1:0] phys_addr(input logic [WORD_W-1:0] seg,
                                                  input logic [WORD_W-1:0] off);
    return {seg, 4'h0} + {4'h0, off};
  endfunction

  function automatic logic [ADDR_W-1:0] table_addr(input logic [7:0] vec, input logic hi);
    return {10'h000, vec, hi, 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] entry_flags(input logic [WORD_W-1:0] f);
    logic [WORD_W-1:0] r;
    r = f;
    r[IF_BIT] = 1'b0;
    r[TF_BIT] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/irq_nmi_qual.sv
module irq_nmi_qual #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic take_i,
  output logic pend_o,
  output logic set_o
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign set_o = nmi_i && armed_q && (cnt_q == CW'(HOLD));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
      pend_o  <= 1'b0;
    end else begin
      if (take_i) pend_o <= 1'b0;
      if (!nmi_i) begin
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (armed_q) begin
        if (set_o) begin
          pend_o  <= 1'b1;
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter import irq_pkg::*; (
  input  logic       boundary_i,
  input  logic       busy_i,
  input  logic       div_fault_i,
  input  logic       ovf_trap_i,
  input  logic       of_flag_i,
  input  logic       sw_req_i,
  input  logic [7:0] sw_vec_i,
  input  logic       iret_i,
  input  logic       nmi_pend_i,
  input  logic       ext_inhibit_i,
  input  logic       intr_req_i,
  input  logic       if_flag_i,
  input  logic [7:0] intr_vec_i,
  output logic       take_ent_o,
  output logic       take_ret_o,
  output logic       take_nmi_o,
  output src_t       src_o,
  output logic [7:0] vec_o
);
  always_comb begin
    take_ent_o = 1'b0;
    take_ret_o = 1'b0;
    take_nmi_o = 1'b0;
    src_o      = SRC_NONE;
    vec_o      = 8'h00;
    if (boundary_i && !busy_i) begin
      if (div_fault_i) begin
        take_ent_o = 1'b1; src_o = SRC_INT; vec_o = VEC_DIV;
      end else if (ovf_trap_i && of_flag_i) begin
        take_ent_o = 1'b1; src_o = SRC_INT; vec_o = VEC_OVF;
      end else if (sw_req_i) begin
        take_ent_o = 1'b1; src_o = SRC_INT; vec_o = sw_vec_i;
      end else if (iret_i) begin
        take_ret_o = 1'b1;
      end else if (nmi_pend_i && !ext_inhibit_i) begin
        take_ent_o = 1'b1; take_nmi_o = 1'b1; src_o = SRC_NMI; vec_o = VEC_NMI;
      end else if (intr_req_i && if_flag_i && !ext_inhibit_i) begin
        take_ent_o = 1'b1; src_o = SRC_EXT; vec_o = intr_vec_i;
      end
    end
  end
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm import irq_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ent_i,
  input  logic              start_ret_i,
  input  logic [7:0]        vec_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              load_o,
  output logic              ret_mode_o,
  output logic [WORD_W-1:0] new_cs_o,
  output logic [WORD_W-1:0] new_ip_o,
  output logic [WORD_W-1:0] new_flags_o,
  output logic [WORD_W-1:0] new_sp_o
);
  seq_t              st_q;
  logic [7:0]        vec_q;
  logic [WORD_W-1:0] ss_q, sp_q, flags_q, cs_q, ip_q;
  logic [WORD_W-1:0] tgt_ip_q, tgt_cs_q, tgt_flags_q;
  logic              ret_q;

  assign busy_o      = (st_q != S_IDLE);
  assign load_o      = (st_q == S_LOAD);
  assign ret_mode_o  = ret_q;
  assign new_cs_o    = tgt_cs_q;
  assign new_ip_o    = tgt_ip_q;
  assign new_flags_o = tgt_flags_q;
  assign new_sp_o    = sp_q;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st_q)
      S_PUSH_F, S_PUSH_CS, S_PUSH_IP: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = phys_addr(ss_q, sp_q - 16'd2);
        mem_wdata_o = (st_q == S_PUSH_F) ? flags_q : (st_q == S_PUSH_CS) ? cs_q : ip_q;
      end
      S_RD_OFF: begin mem_req_o = 1'b1; mem_addr_o = table_addr(vec_q, 1'b0); end
      S_RD_SEG: begin mem_req_o = 1'b1; mem_addr_o = table_addr(vec_q, 1'b1); end
      S_POP_IP, S_POP_CS, S_POP_F: begin
        mem_req_o  = 1'b1;
        mem_addr_o = phys_addr(ss_q, sp_q);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      vec_q <= '0;
      ss_q <= '0; sp_q <= '0; flags_q <= '0; cs_q <= '0; ip_q <= '0;
      tgt_ip_q <= '0; tgt_cs_q <= '0; tgt_flags_q <= '0;
      ret_q <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_ent_i) begin
            vec_q <= vec_i; ss_q <= ss_i; sp_q <= sp_i;
            flags_q <= flags_i; cs_q <= cs_i; ip_q <= ip_i;
            tgt_flags_q <= entry_flags(flags_i);
            ret_q <= 1'b0;
            st_q  <= S_PUSH_F;
          end else if (start_ret_i) begin
            ss_q <= ss_i; sp_q <= sp_i;
            ret_q <= 1'b1;
            st_q  <= S_POP_IP;
          end
        end
        S_PUSH_F:  if (mem_ack_i) begin sp_q <= sp_q - 16'd2; st_q <= S_PUSH_CS; end
        S_PUSH_CS: if (mem_ack_i) begin sp_q <= sp_q - 16'd2; st_q <= S_PUSH_IP; end
        S_PUSH_IP: if (mem_ack_i) begin sp_q <= sp_q - 16'd2; st_q <= S_RD_OFF; end
        S_RD_OFF:  if (mem_ack_i) begin tgt_ip_q <= mem_rdata_i; st_q <= S_RD_SEG; end
        S_RD_SEG:  if (mem_ack_i) begin tgt_cs_q <= mem_rdata_i; st_q <= S_LOAD; end
        S_POP_IP:  if (mem_ack_i) begin tgt_ip_q <= mem_rdata_i; sp_q <= sp_q + 16'd2; st_q <= S_POP_CS; end
        S_POP_CS:  if (mem_ack_i) begin tgt_cs_q <= mem_rdata_i; sp_q <= sp_q + 16'd2; st_q <= S_POP_F; end
        S_POP_F:   if (mem_ack_i) begin tgt_flags_q <= mem_rdata_i; sp_q <= sp_q + 16'd2; st_q <= S_LOAD; end
        default:   st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq import irq_pkg::*; #(
  parameter int NMI_HOLD = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              ss_write_i,
  input  logic              nmi_i,
  input  logic              intr_req_i,
  input  logic [7:0]        intr_vec_i,
  input  logic              sw_req_i,
  input  logic [7:0]        sw_vec_i,
  input  logic              div_fault_i,
  input  logic              ovf_trap_i,
  input  logic              iret_i,
  input  logic [WORD_W-1:0] flags_i,
  input  logic [WORD_W-1:0] cs_i,
  input  logic [WORD_W-1:0] ip_i,
  input  logic [WORD_W-1:0] ss_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              accept_o,
  output logic [7:0]        accept_vec_o,
  output logic              busy_o,
  output logic              load_o,
  output logic [WORD_W-1:0] new_cs_o,
  output logic [WORD_W-1:0] new_ip_o,
  output logic [WORD_W-1:0] new_flags_o,
  output logic [WORD_W-1:0] new_sp_o
);
  // Named internal events, brought out for the bound checker.
  logic nmi_pend, nmi_set, take_nmi, take_ret;
  logic ss_shadow, ext_inhibit, ret_mode;
  src_t acc_src;

  always_ff @(posedge clk) begin
    if (!rst_n)               ss_shadow <= 1'b0;
    else if (ss_write_i)      ss_shadow <= !boundary_i;
    else if (boundary_i)      ss_shadow <= 1'b0;
  end
  assign ext_inhibit = ss_shadow || ss_write_i;

  irq_nmi_qual #(.HOLD(NMI_HOLD)) nmi_q_i (
    .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .take_i(take_nmi),
    .pend_o(nmi_pend), .set_o(nmi_set)
  );

  irq_arbiter arb_i (
    .boundary_i(boundary_i), .busy_i(busy_o),
    .div_fault_i(div_fault_i), .ovf_trap_i(ovf_trap_i), .of_flag_i(flags_i[OF_BIT]),
    .sw_req_i(sw_req_i), .sw_vec_i(sw_vec_i), .iret_i(iret_i),
    .nmi_pend_i(nmi_pend), .ext_inhibit_i(ext_inhibit),
    .intr_req_i(intr_req_i), .if_flag_i(flags_i[IF_BIT]), .intr_vec_i(intr_vec_i),
    .take_ent_o(accept_o), .take_ret_o(take_ret), .take_nmi_o(take_nmi),
    .src_o(acc_src), .vec_o(accept_vec_o)
  );

  irq_seq_fsm seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_ent_i(accept_o), .start_ret_i(take_ret), .vec_i(accept_vec_o),
    .flags_i(flags_i), .cs_i(cs_i), .ip_i(ip_i), .ss_i(ss_i), .sp_i(sp_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i),
    .busy_o(busy_o), .load_o(load_o), .ret_mode_o(ret_mode),
    .new_cs_o(new_cs_o), .new_ip_o(new_ip_o), .new_flags_o(new_flags_o), .new_sp_o(new_sp_o)
  );
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk import irq_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_i,
  input logic              nmi_pend,
  input logic              ss_shadow,
  input logic              ss_write_i,
  input logic              accept_o,
  input logic [7:0]        accept_vec_o,
  input src_t              acc_src,
  input logic [WORD_W-1:0] flags_i,
  input logic              busy_o,
  input logic              load_o,
  input logic              ret_mode,
  input logic [WORD_W-1:0] new_flags_o,
  input logic              mem_req_o,
  input logic              mem_we_o
);
  p_nmi_vector_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && acc_src == SRC_NMI |-> accept_vec_o == VEC_NMI);

  p_nmi_needs_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_pend) |-> $past(nmi_i));

  p_mask_needs_if_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && acc_src == SRC_EXT |-> flags_i[IF_BIT]);

  p_shadow_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && (acc_src == SRC_NMI || acc_src == SRC_EXT) |-> !ss_shadow && !ss_write_i);

  p_entry_starts_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o |=> busy_o && mem_req_o && mem_we_o);

  p_entry_clears_if_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_o && !ret_mode |-> !new_flags_o[IF_BIT] && !new_flags_o[TF_BIT]);

  p_busy_no_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !accept_o);

  p_load_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !busy_o);
endmodule

bind irq_entry_seq irq_entry_chk chk_i (
  .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .nmi_pend(nmi_pend),
  .ss_shadow(ss_shadow), .ss_write_i(ss_write_i),
  .accept_o(accept_o), .accept_vec_o(accept_vec_o), .acc_src(acc_src),
  .flags_i(flags_i), .busy_o(busy_o), .load_o(load_o), .ret_mode(ret_mode),
  .new_flags_o(new_flags_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic boundary_i, ss_write_i, nmi_i, intr_req_i, sw_req_i, div_fault_i, ovf_trap_i, iret_i;
  logic [7:0] intr_vec_i, sw_vec_i;
  logic [15:0] flags_i, cs_i, ip_i, ss_i, sp_i;
  logic mem_req_o, mem_we_o, mem_ack_i;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, mem_rdata_i;
  logic accept_o, busy_o, load_o;
  logic [7:0] accept_vec_o;
  logic [15:0] new_cs_o, new_ip_o, new_flags_o, new_sp_o;

  always #2 clk = ~clk;

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ss_write_i(ss_write_i),
    .nmi_i(nmi_i), .intr_req_i(intr_req_i), .intr_vec_i(intr_vec_i),
    .sw_req_i(sw_req_i), .sw_vec_i(sw_vec_i), .div_fault_i(div_fault_i),
    .ovf_trap_i(ovf_trap_i), .iret_i(iret_i), .flags_i(flags_i), .cs_i(cs_i),
    .ip_i(ip_i), .ss_i(ss_i), .sp_i(sp_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i), .accept_o(accept_o), .accept_vec_o(accept_vec_o),
    .busy_o(busy_o), .load_o(load_o), .new_cs_o(new_cs_o), .new_ip_o(new_ip_o),
    .new_flags_o(new_flags_o), .new_sp_o(new_sp_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mem [logic [19:0]];
  logic [19:0] wr_a [64];
  logic [15:0] wr_d [64];
  logic [19:0] rd_a [64];
  int wr_n = 0;
  int rd_n = 0;
  int acc_cnt = 0;
  int load_cnt = 0;
  logic [7:0] last_vec;
  logic [15:0] ld_cs, ld_ip, ld_flags, ld_sp;

  // Memory model: acknowledge one cycle after a request appears.
  initial begin
    mem_ack_i = 1'b0;
    mem_rdata_i = '0;
    forever begin
      @(negedge clk);
      if (mem_req_o && !mem_ack_i) begin
        mem_ack_i = 1'b1;
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          if (wr_n < 64) begin wr_a[wr_n] = mem_addr_o; wr_d[wr_n] = mem_wdata_o; end
          wr_n++;
        end else begin
          mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : 16'h0000;
          if (rd_n < 64) rd_a[rd_n] = mem_addr_o;
          rd_n++;
        end
      end else begin
        mem_ack_i = 1'b0;
      end
    end
  end

  // Output monitor, sampling one ns after the falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (accept_o) begin acc_cnt++; last_vec = accept_vec_o; end
      if (load_o) begin
        load_cnt++;
        ld_cs = new_cs_o; ld_ip = new_ip_o; ld_flags = new_flags_o; ld_sp = new_sp_o;
      end
    end
  end

  initial begin
    #600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step_boundary();
    boundary_i = 1'b1;
    @(negedge clk);
    boundary_i = 1'b0;
  endtask

  task automatic wait_load(input string req);
    int t0 = load_cnt;
    int n = 0;
    while (load_cnt == t0 && n < 200) begin @(negedge clk); n++; end
    chk(req, "load pulse count", load_cnt - t0, 1);
    tick(2);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    boundary_i = 0; ss_write_i = 0; nmi_i = 0; intr_req_i = 0; sw_req_i = 0;
    div_fault_i = 0; ovf_trap_i = 0; iret_i = 0; intr_vec_i = 0; sw_vec_i = 0;
    flags_i = 16'h0002; cs_i = 16'h1234; ip_i = 16'h5678; ss_i = 16'h2000; sp_i = 16'h0100;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    chk("R12", "busy after reset", busy_o, 0);
    chk("R12", "mem_req after reset", mem_req_o, 0);
    chk("R12", "load after reset", load_o, 0);
    chk("R12", "accept after reset", accept_o, 0);
  endtask

  task automatic t_intr_entry();
    int w0 = wr_n;
    int r0 = rd_n;
    int a0 = acc_cnt;
    mem[20'h001C0] = 16'hABCD; mem[20'h001C2] = 16'h4321;
    flags_i = 16'h0302; sp_i = 16'h0100;
    intr_req_i = 1; intr_vec_i = 8'h70;
    step_boundary();
    intr_req_i = 0;
    chk("R3", "maskable accepted with IF=1", acc_cnt - a0, 1);
    chk("R3", "maskable vector", last_vec, 8'h70);
    wait_load("R9");
    chk("R8", "push count", wr_n - w0, 3);
    chk("R8", "flags push addr", wr_a[w0], 20'h200FE);
    chk("R8", "flags push data", wr_d[w0], 16'h0302);
    chk("R8", "cs push addr", wr_a[w0+1], 20'h200FC);
    chk("R8", "cs push data", wr_d[w0+1], 16'h1234);
    chk("R8", "ip push addr", wr_a[w0+2], 20'h200FA);
    chk("R8", "ip push data", wr_d[w0+2], 16'h5678);
    chk("R9", "offset read addr", rd_a[r0], 20'h001C0);
    chk("R9", "segment read addr", rd_a[r0+1], 20'h001C2);
    chk("R9", "new ip", ld_ip, 16'hABCD);
    chk("R9", "new cs", ld_cs, 16'h4321);
    chk("R9", "new flags IF TF clear", ld_flags, 16'h0002);
    chk("R9", "new sp", ld_sp, 16'h00FA);
  endtask

  task automatic t_return();
    int r0 = rd_n;
    int a0 = acc_cnt;
    sp_i = 16'h00FA; flags_i = 16'h0002;
    iret_i = 1;
    step_boundary();
    iret_i = 0;
    wait_load("R10");
    chk("R10", "return is not an accept", acc_cnt - a0, 0);
    chk("R10", "pop ip addr", rd_a[r0], 20'h200FA);
    chk("R10", "pop cs addr", rd_a[r0+1], 20'h200FC);
    chk("R10", "pop flags addr", rd_a[r0+2], 20'h200FE);
    chk("R10", "restored ip", ld_ip, 16'h5678);
    chk("R10", "restored cs", ld_cs, 16'h1234);
    chk("R10", "restored flags", ld_flags, 16'h0302);
    chk("R10", "restored sp", ld_sp, 16'h0100);
    sp_i = 16'h0100;
  endtask

  task automatic t_masked();
    int a0 = acc_cnt;
    int w0 = wr_n;
    flags_i = 16'h0002;
    intr_req_i = 1; intr_vec_i = 8'h70;
    for (int i = 0; i < 3; i++) begin step_boundary(); tick(1); end
    intr_req_i = 0;
    tick(4);
    chk("R3", "maskable ignored with IF=0", acc_cnt - a0, 0);
    chk("R3", "no stack write with IF=0", wr_n - w0, 0);
  endtask

  task automatic t_div();
    int a0 = acc_cnt;
    mem[20'h00000] = 16'h1111; mem[20'h00002] = 16'h2222;
    flags_i = 16'h0002;
    div_fault_i = 1;
    step_boundary();
    div_fault_i = 0;
    chk("R4", "divide fault accepted", acc_cnt - a0, 1);
    chk("R4", "divide fault vector", last_vec, 8'h00);
    wait_load("R4");
    chk("R4", "divide handler ip", ld_ip, 16'h1111);
    chk("R4", "divide handler cs", ld_cs, 16'h2222);
  endtask

  task automatic t_ovf();
    int a0 = acc_cnt;
    int w0 = wr_n;
    mem[20'h00010] = 16'h3333; mem[20'h00012] = 16'h4444;
    flags_i = 16'h0002;
    ovf_trap_i = 1;
    step_boundary();
    ovf_trap_i = 0;
    tick(4);
    chk("R4", "overflow trap ignored with OF=0", acc_cnt - a0, 0);
    chk("R4", "no stack write with OF=0", wr_n - w0, 0);
    flags_i = 16'h0802;
    ovf_trap_i = 1;
    step_boundary();
    ovf_trap_i = 0;
    chk("R4", "overflow trap vector", last_vec, 8'h04);
    wait_load("R4");
    chk("R4", "overflow handler ip", ld_ip, 16'h3333);
    chk("R9", "flags keep OF", ld_flags, 16'h0802);
  endtask

  task automatic t_soft();
    int r0 = rd_n;
    mem[20'h00084] = 16'h5555; mem[20'h00086] = 16'h6666;
    flags_i = 16'h0002;
    sw_req_i = 1; sw_vec_i = 8'h21;
    step_boundary();
    sw_req_i = 0;
    chk("R5", "soft vector with IF=0", last_vec, 8'h21);
    wait_load("R5");
    chk("R5", "soft table addr", rd_a[r0], 20'h00084);
    chk("R5", "soft handler cs", ld_cs, 16'h6666);
  endtask

  task automatic t_nmi();
    int a0 = acc_cnt;
    flags_i = 16'h0002;
    nmi_i = 1; tick(4); nmi_i = 0; tick(2);
    step_boundary();
    chk("R1", "4-cycle NMI pulse ignored", acc_cnt - a0, 0);
    tick(2);
    nmi_i = 1; tick(6);
    step_boundary();
    chk("R1", "held NMI accepted with IF=0", acc_cnt - a0, 1);
    chk("R1", "NMI vector", last_vec, 8'h02);
    wait_load("R1");
    step_boundary();
    tick(2);
    step_boundary();
    chk("R2", "one acceptance per high period", acc_cnt - a0, 1);
    nmi_i = 0;
    tick(2);
  endtask

  task automatic t_priority();
    flags_i = 16'h0202;
    nmi_i = 1; tick(6); nmi_i = 0; tick(1);
    sw_req_i = 1; sw_vec_i = 8'h30; intr_req_i = 1; intr_vec_i = 8'h70;
    step_boundary();
    sw_req_i = 0;
    chk("R6", "soft wins over NMI and maskable", last_vec, 8'h30);
    wait_load("R6");
    step_boundary();
    chk("R6", "NMI wins over maskable", last_vec, 8'h02);
    wait_load("R6");
    step_boundary();
    chk("R6", "maskable taken last", last_vec, 8'h70);
    wait_load("R6");
    intr_req_i = 0;
  endtask

  task automatic t_shadow();
    int a0 = acc_cnt;
    flags_i = 16'h0202;
    intr_req_i = 1; intr_vec_i = 8'h70;
    ss_write_i = 1; tick(1); ss_write_i = 0; tick(2);
    step_boundary();
    chk("R7", "boundary after SS write blocked", acc_cnt - a0, 0);
    tick(1);
    step_boundary();
    chk("R7", "following boundary open", acc_cnt - a0, 1);
    wait_load("R7");
    ss_write_i = 1;
    step_boundary();
    ss_write_i = 0;
    chk("R7", "coinciding SS write blocks", acc_cnt - a0, 1);
    tick(1);
    step_boundary();
    chk("R7", "open after coinciding case", acc_cnt - a0, 2);
    wait_load("R7");
    intr_req_i = 0;
  endtask

  task automatic t_busy();
    int a0 = acc_cnt;
    int w0 = wr_n;
    flags_i = 16'h0002;
    sw_req_i = 1; sw_vec_i = 8'h21;
    step_boundary();
    sw_vec_i = 8'h22;
    chk("R11", "busy after accept", busy_o, 1);
    step_boundary();
    sw_req_i = 0;
    wait_load("R11");
    chk("R11", "no accept while busy", acc_cnt - a0, 1);
    chk("R11", "vector of first request", last_vec, 8'h21);
    chk("R11", "only one entry pushed", wr_n - w0, 3);
    chk("R11", "idle after load", busy_o, 0);
  endtask

  initial begin
    t_reset();
    t_intr_entry();
    t_return();
    t_masked();
    t_div();
    t_ovf();
    t_soft();
    t_nmi();
    t_priority();
    t_shadow();
    t_busy();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule